// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic unit of a small 8-bit datapath. Each operation takes a left and a right 8-bit operand, an operation select and a carry-in, and produces an 8-bit result combinationally in the same cycle. The operations that use both operands are binary add with carry-in, decimal (BCD) add, compare, AND, OR and XOR. The operations that use only the left operand are complement, increment, decrement, shift left, shift right and clear.

For every operation the block also works out four flags: sign, carry, zero and overflow. A registered 4-bit status word stores them. When an operation is issued, the flag-write mask that comes with it chooses which status bits take their new values, so that each instruction class updates only the flags it owns. Logic outside the block handles instruction decode, operand selection and the accumulator.

Top module: `alu8_flags`

## Requirements
- R1: Operation codes on `op_sel` are 0 add, 1 decimal add, 2 compare, 3 AND, 4 OR, 5 XOR, 6 complement, 7 increment, 8 decrement, 9 shift left, 10 shift right and 11 clear. Add drives `result` with (lhs + rhs + carry_in) mod 256.
- R2: Status bit 1 is the carry flag. For add, increment, decrement and compare it is the carry out of bit 7 of the internal addition, which works as a ninth result bit. For example, 0x9D+0xD1 sets it and 0x65+0x76 clears it. Increment sets carry only from 0xFF. Decrement sets carry for every operand except 0x00.
- R3: Status bit 3 is the overflow flag. For add, increment, decrement and compare it is the XOR of the carries out of bits 6 and 7. For example, 0xB3+0x71 gives overflow 0 with carry 1, and 0x67+0x24 gives overflow 1 with carry 0.
- R4: Status bit 0 is the sign flag. It is written with the inverse of bit 7 of the flag value.
- R5: Status bit 2 is the zero flag. It is written with 1 when the flag value is 0x00 and with 0 otherwise. The flag value is the result, except for compare, where it is the difference.
- R6: AND, OR, XOR and complement (~lhs) give the bitwise result and write 0 to both carry and overflow.
- R7: Shift left and shift right move lhs by one place and fill the vacated bit with 0. Clear gives 0x00. All three write 0 to carry and overflow.
- R8: Compare computes rhs - lhs, which sets carry exactly when rhs >= lhs unsigned. It takes sign, zero and overflow from that difference and passes lhs unchanged to `result`.
- R9: Decimal add treats both operands as two-digit BCD. It corrects each nibble using the nibble carries, drives the two-digit BCD sum (mod 100) on `result` and sets carry when the decimal sum is 100 or more. Its overflow follows the binary sum of the same operands.
- R10: A status bit changes only on a clock edge where `op_valid` is high and its `flag_wr_mask` bit is 1. All other status bits keep their values.
- R11: Reset (active-low `rst_n`) clears the status word to 0.
- R12: Codes 12 to 15 give result 0x00 and leave the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation issued this cycle; enables the flag write |
| op_sel | input | 4 | Operation code |
| lhs | input | 8 | Left operand |
| rhs | input | 8 | Right operand |
| carry_in | input | 1 | Carry into binary add |
| flag_wr_mask | input | 4 | Per-flag write enable: bit0 sign, bit1 carry, bit2 zero, bit3 overflow |
| result | output | 8 | Combinational operation result |
| status | output | 4 | Registered flags: bit0 sign, bit1 carry, bit2 zero, bit3 overflow |

## Verification
Every binary and single-operand code is run against all 256 left operands, each paired with sixteen right operands. The right operands include 0x00, 0x01, 0x7F, 0x80 and 0xFF. These values place the edges of signed overflow, unsigned carry and zero on both sides of each sum, so a carry taken from the wrong bit or an overflow built from the operand signs alone shows up as a mismatch. Decimal add is swept over every pair of valid BCD operands, which covers each nibble-correction case and the carry out at sums of 100 and above. The flag-write mask and `op_valid` change with the operand pattern, and the bench keeps its own copy of the status word, so a flag written without its mask bit, or held when it should have been written, is told apart from a flag that was computed wrong.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int NFL = 4;
  localparam int OPW = 4;

  // status bit positions
  localparam int FL_S = 0;
  localparam int FL_C = 1;
  localparam int FL_Z = 2;
  localparam int FL_V = 3;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_DADD = 4'd1,
    OP_CMP  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_COM  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_SHL  = 4'd9,
    OP_SHR  = 4'd10,
    OP_CLR  = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic [DW-1:0] sum;
    logic          c_msb_in;  // carry out of bit DW-2
    logic          c_msb_out; // carry out of bit DW-1
  } add_res_t;

  typedef struct packed {
    logic [7:0] sum;
    logic       cout;
  } bcd_res_t;

  // ripple sum with both top carries exposed
  function automatic add_res_t add_chain(input logic [DW-1:0] x,
                                         input logic [DW-1:0] y,
                                         input logic          ci);
    logic [DW:0] full;
    add_res_t    r;
    full        = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
    r.sum       = full[DW-1:0];
    r.c_msb_out = full[DW];
    r.c_msb_in  = x[DW-1] ^ y[DW-1] ^ full[DW-1];
    return r;
  endfunction

  // two-digit packed decimal add with per-nibble correction
  function automatic bcd_res_t bcd_add(input logic [7:0] x, input logic [7:0] y);
    logic [4:0] lo;
    logic [4:0] hi;
    logic       lc;
    logic       hc;
    bcd_res_t   r;
    lo         = {1'b0, x[3:0]} + {1'b0, y[3:0]};
    lc         = lo > 5'd9;
    r.sum[3:0] = lo[3:0] + {1'b0, lc, lc, 1'b0};
    hi         = {1'b0, x[7:4]} + {1'b0, y[7:4]} + {4'b0, lc};
    hc         = hi > 5'd9;
    r.sum[7:4] = hi[3:0] + {1'b0, hc, hc, 1'b0};
    r.cout     = hc;
    return r;
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  input  logic          cin,
  output logic [DW-1:0] val,
  output logic          carry,
  output logic          ovf,
  output logic          c6,
  output logic          c7
);
  logic [DW-1:0] x_op;
  logic [DW-1:0] y_op;
  logic          ci_op;
  add_res_t      ar;
  bcd_res_t      br;

  always_comb begin
    x_op  = lhs;
    y_op  = rhs;
    ci_op = cin;
    case (op)
      OP_CMP:  begin x_op = rhs; y_op = ~lhs; ci_op = 1'b1; end
      OP_INC:  begin y_op = '0;  ci_op = 1'b1; end
      OP_DEC:  begin y_op = '1;  ci_op = 1'b0; end
      OP_DADD: ci_op = 1'b0;
      default: ;
    endcase
  end

  assign ar = add_chain(x_op, y_op, ci_op);
  assign br = bcd_add(lhs, rhs);
  assign c6 = ar.c_msb_in;
  assign c7 = ar.c_msb_out;

  always_comb begin
    ovf = ar.c_msb_in ^ ar.c_msb_out;
    if (op == OP_DADD) begin
      val   = br.sum;
      carry = br.cout;
    end else begin
      val   = ar.sum;
      carry = ar.c_msb_out;
    end
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  output logic [DW-1:0] val
);
  always_comb begin
    case (op)
      OP_AND:  val = lhs & rhs;
      OP_OR:   val = lhs | rhs;
      OP_XOR:  val = lhs ^ rhs;
      OP_COM:  val = ~lhs;
      OP_SHL:  val = {lhs[DW-2:0], 1'b0};
      OP_SHR:  val = {1'b0, lhs[DW-1:1]};
      default: val = '0;
    endcase
  end
endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg
  import alu8_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [NFL-1:0] mask,
  input  logic [NFL-1:0] flag_new,
  output logic [NFL-1:0] status_q
);
  logic [NFL-1:0] nxt;

  for (genvar i = 0; i < NFL; i++) begin : g_bit
    assign nxt[i] = (wr_en && mask[i]) ? flag_new[i] : status_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= nxt;
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [3:0]  op_sel,
  input  logic [7:0]  lhs,
  input  logic [7:0]  rhs,
  input  logic        carry_in,
  input  logic [3:0]  flag_wr_mask,
  output logic [7:0]  result,
  output logic [3:0]  status
);
  alu_op_e        op;
  logic           is_arith;
  logic           is_logic;
  logic [DW-1:0]  arith_val;
  logic [DW-1:0]  logic_val;
  logic [DW-1:0]  flag_src;
  logic           arith_c;
  logic           arith_v;
  logic           add_c6;  // carry out of bit 6, for the checker
  logic           add_c7;  // carry out of bit 7, for the checker
  logic           flag_wr;
  logic [NFL-1:0] flag_new;

  assign op = alu_op_e'(op_sel);

  always_comb begin
    is_arith = 1'b0;
    is_logic = 1'b0;
    case (op)
      OP_ADD, OP_DADD, OP_CMP, OP_INC, OP_DEC:           is_arith = 1'b1;
      OP_AND, OP_OR, OP_XOR, OP_COM, OP_SHL, OP_SHR, OP_CLR: is_logic = 1'b1;
      default: ;
    endcase
  end

  alu8_arith u_arith (
    .op    (op),
    .lhs   (lhs),
    .rhs   (rhs),
    .cin   (carry_in),
    .val   (arith_val),
    .carry (arith_c),
    .ovf   (arith_v),
    .c6    (add_c6),
    .c7    (add_c7)
  );

  alu8_logic u_logic (
    .op  (op),
    .lhs (lhs),
    .rhs (rhs),
    .val (logic_val)
  );

  assign flag_src = is_arith ? arith_val : logic_val;

  always_comb begin
    if (op == OP_CMP)   result = lhs;
    else if (is_arith)  result = arith_val;
    else                result = logic_val;
  end

  always_comb begin
    flag_new       = '0;
    flag_new[FL_S] = ~flag_src[DW-1];
    flag_new[FL_Z] = (flag_src == '0);
    flag_new[FL_C] = is_arith & arith_c;
    flag_new[FL_V] = is_arith & arith_v;
  end

  assign flag_wr = op_valid & (is_arith | is_logic);

  alu8_status_reg u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (flag_wr),
    .mask     (flag_wr_mask),
    .flag_new (flag_new),
    .status_q (status)
  );
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [3:0] op_sel,
  input logic [7:0] lhs,
  input logic [7:0] rhs,
  input logic [3:0] flag_wr_mask,
  input logic [7:0] result,
  input logic [3:0] status,
  input logic       add_c6,
  input logic       add_c7
);
  p_reset_r11: assert property (@(posedge clk) !rst_n |=> status == 4'h0);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(status));

  p_mask_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && flag_wr_mask == 4'h0) |=> $stable(status));

  p_unused_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel >= 4'd12) |=> $stable(status));

  p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && flag_wr_mask[FL_S] && op_sel != OP_CMP && op_sel < 4'd12)
    |=> status[FL_S] == !$past(result[7]));

  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && flag_wr_mask[FL_Z] && op_sel != OP_CMP && op_sel < 4'd12)
    |=> status[FL_Z] == ($past(result) == 8'h00));

  p_logic_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && flag_wr_mask[FL_C] && op_sel inside {OP_AND, OP_OR, OP_XOR, OP_COM})
    |=> !status[FL_C]);

  p_cmp_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && flag_wr_mask[FL_C] && op_sel == OP_CMP)
    |=> status[FL_C] == ($past(rhs) >= $past(lhs)));

  p_add_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && flag_wr_mask[FL_V] && op_sel == OP_ADD)
    |=> status[FL_V] == ($past(lhs[7]) == $past(rhs[7]) && $past(result[7]) != $past(lhs[7])));

  p_carry_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_ADD) |-> ((add_c6 != add_c7) == (lhs[7] == rhs[7] && result[7] != lhs[7])));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_CLR) |-> result == 8'h00);
endmodule

bind alu8_flags alu8_flags_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_sel       (op_sel),
  .lhs          (lhs),
  .rhs          (rhs),
  .flag_wr_mask (flag_wr_mask),
  .result       (result),
  .status       (status),
  .add_c6       (add_c6),
  .add_c7       (add_c7)
);

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] lhs = 8'h00;
  logic [7:0] rhs = 8'h00;
  logic       carry_in = 1'b0;
  logic [3:0] flag_wr_mask = 4'h0;
  logic [7:0] result;
  logic [3:0] status;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;
  logic [3:0] exp_st = 4'h0;

  always #2.5 clk = ~clk;

  alu8_flags dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_sel       (op_sel),
    .lhs          (lhs),
    .rhs          (rhs),
    .carry_in     (carry_in),
    .flag_wr_mask (flag_wr_mask),
    .result       (result),
    .status       (status)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int to_signed8(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // returns {known, V, Z, C, S, result[7:0]}
  function automatic logic [12:0] model(input int op, input int a, input int b, input int c);
    int res, val, sv, da, db, ds;
    bit cf, vf, known;
    cf = 0; vf = 0; known = 1; res = 0;
    case (op)
      0: begin
        res = (a + b + c) % 256; val = res; cf = (a + b + c) > 255;
        sv = to_signed8(a) + to_signed8(b) + c; vf = (sv > 127) || (sv < -128);
      end
      1: begin
        da = (a / 16) * 10 + (a % 16); db = (b / 16) * 10 + (b % 16);
        ds = da + db; cf = ds >= 100; ds = ds % 100;
        res = (ds / 10) * 16 + (ds % 10); val = res;
        sv = to_signed8(a) + to_signed8(b); vf = (sv > 127) || (sv < -128);
      end
      2: begin
        res = a; val = (b - a + 256) % 256; cf = b >= a;
        sv = to_signed8(b) - to_signed8(a); vf = (sv > 127) || (sv < -128);
      end
      3: begin res = a & b; val = res; end
      4: begin res = a | b; val = res; end
      5: begin res = a ^ b; val = res; end
      6: begin res = 255 - a; val = res; end
      7: begin res = (a + 1) % 256; val = res; cf = (a == 255); vf = (a == 127); end
      8: begin res = (a + 255) % 256; val = res; cf = (a != 0); vf = (a == 128); end
      9: begin res = (a * 2) % 256; val = res; end
      10: begin res = a / 2; val = res; end
      11: begin res = 0; val = 0; end
      default: begin res = 0; val = 0; known = 0; end
    endcase
    return {known, vf, (val == 0), cf, (val < 128), res[7:0]};
  endfunction

  function automatic int pick_rhs(input int i);
    case (i)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h7F;  3: return 8'h80;
      4: return 8'hFF;  5: return 8'h76;  6: return 8'hD1;  7: return 8'h71;
      8: return 8'h24;
      default: return (i * 37 + 11) % 256;
    endcase
  endfunction

  function automatic string res_tag(input int op);
    case (op)
      0: return "R1";   1: return "R9";   2: return "R8";
      3, 4, 5, 6: return "R6";
      7, 8: return "R2";
      9, 10, 11: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic run_op(input int op, input int a, input int b, input int c,
                        input logic [3:0] m, input bit v);
    logic [12:0] mr;
    @(negedge clk);
    op_sel = op[3:0]; lhs = a[7:0]; rhs = b[7:0]; carry_in = c[0];
    flag_wr_mask = m; op_valid = v;
    #1;
    mr = model(op, a, b, c);
    check(result == mr[7:0], res_tag(op), result, mr[7:0]);
    // R10: only masked bits of a valid, known op are written
    if (v && mr[12]) begin
      for (int i = 0; i < 4; i++) if (m[i]) exp_st[i] = mr[8+i];
    end
    @(posedge clk);
    #1;
    check(status[0] == exp_st[0], (m[0] && v) ? "R4 sign" : "R10 sign", status, exp_st);
    check(status[1] == exp_st[1], (m[1] && v) ? "R2 carry" : "R10 carry", status, exp_st);
    check(status[2] == exp_st[2], (m[2] && v) ? "R5 zero" : "R10 zero", status, exp_st);
    check(status[3] == exp_st[3], (m[3] && v) ? "R3 overflow" : "R10 overflow", status, exp_st);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(status == 4'h0, "R11 reset", status, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // worked examples for R2 and R3
    run_op(0, 8'h9D, 8'hD1, 0, 4'hF, 1);
    check(status[1] == 1'b1, "R2 9D+D1 carry", status, 1);
    run_op(0, 8'h65, 8'h76, 0, 4'hF, 1);
    check(status[1] == 1'b0, "R2 65+76 carry", status, 0);
    run_op(0, 8'hB3, 8'h71, 0, 4'hF, 1);
    check(status[3:1] == 3'b001, "R3 B3+71", status, 4'b0010);
    run_op(0, 8'h67, 8'h24, 0, 4'hF, 1);
    check(status[3] == 1'b1 && status[1] == 1'b0, "R3 67+24", status, 4'b1000);

    // main sweep over every binary/single-operand code and unused codes
    for (int op = 0; op < 16; op++) begin
      if (op == 1) continue;
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 16; bi++) begin
          logic [3:0] m;
          bit v;
          m = ((a ^ bi) & 1) ? 4'hF : 4'((a + bi) % 16);
          v = !((a % 7) == 3 && bi == 5);
          run_op(op, a, pick_rhs(bi), bi % 2, m, v);
        end
      end
    end

    // R9: every pair of valid BCD operands
    for (int x = 0; x < 100; x++) begin
      for (int y = 0; y < 100; y++) begin
        run_op(1, (x / 10) * 16 + x % 10, (y / 10) * 16 + y % 10, 1, 4'hF, 1);
      end
    end

    // R10: idle cycles leave status untouched
    run_op(11, 0, 0, 0, 4'hF, 1);
    run_op(0, 8'h80, 8'h80, 0, 4'hF, 0);
    check(status == 4'b0101, "R10 idle hold", status, 4'b0101);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule